// File: doc/BRIEF.md
# Compare-Wrap Timer with Complementary Toggle Output

This block is a small free-running up-counter controlled by one 16-bit control word. While its enable field is set, the counter advances by one on every clock. When the count equals a programmable compare value, the next clock brings it back to zero. That wrap also flips a pair of complementary output pins, so the pins form a square wave whose period follows the compare value. If the interrupt-enable field is set, the wrap also produces a one-cycle interrupt pulse.

Software loads the enable, the interrupt enable and the compare value in a single write. The same write can clear the counter through a one-shot field. The running count is always visible on a 16-bit readback word. Address decoding and interrupt masking sit outside the block.

Top module: `cmp_wrap_timer`

## Requirements
- R1: After asynchronous reset the count reads 0, `q_out` is 0, `nq_out` is 1 and `irq_pulse` is 0. The timer is disabled, so the count stays at 0 until a write enables it.
- R2: A write (`ctl_we` high at a rising edge) stores bit 15 as the enable, bit 13 as the interrupt enable and bits 12..0 as the compare value. Bit 14 is the clear request. The stored fields govern counting from the next edge on. The edge that performs the write still uses the old fields.
- R3: While the timer is enabled and the count differs from the compare value, each clock adds one to the 13-bit count.
- R4: While the timer is enabled and the count equals the compare value, the next clock sets the count to 0. This is a wrap.
- R5: Each wrap inverts `q_out` at the same edge that zeroes the count. `nq_out` is always the inverse of `q_out`.
- R6: `irq_pulse` is high for exactly the cycle after a wrap, and only if the interrupt enable was set when the wrap took place. In every other cycle it is low.
- R7: A write with bit 14 set zeroes the count at that edge, whatever the enable and compare state. That edge is never a wrap: `q_out` keeps its value and no pulse follows. The clear request is not retained.
- R8: While the timer is disabled and no clear is written, the count holds its value.
- R9: Readback bits 15..13 always read 0 and bits 12..0 carry the count.
- R10: With a compare value of 0 and the timer enabled, every clock is a wrap. If the compare value is below the current count, the counter runs up to 8191 and rolls over to 0 without a wrap, then wraps normally when it reaches the compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 16 | Control word: enable, clear, interrupt enable, compare value |
| count_rd | output | 16 | Current count, zero-extended |
| q_out | output | 1 | Toggle output, flips on each wrap |
| nq_out | output | 1 | Inverse of `q_out` |
| irq_pulse | output | 1 | One-cycle pulse following a wrap when interrupts are enabled |

## Verification
The count, the toggle pin and the interrupt pulse all come from the same edge. A faulty compare or step path therefore shows up on `count_rd` in the very next cycle, either as a missed zero or as a wrong increment. A wrong toggle state shows up as an inverted `q_out` from the next wrap onward and never heals, because the reference phase is kept for the rest of the run. Field-decode errors, such as enable or interrupt enable read from the wrong bit, or a clear that lingers, show up within one cycle of the write that exposes them.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_STEP  = 2'd1,
    ACT_WRAP  = 2'd2,
    ACT_CLEAR = 2'd3
  } act_e;
endpackage

// File: rtl/tmr_ctl_reg.sv
module tmr_ctl_reg #(
  parameter int CNT_W = 13,
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [BUS_W-1:0] wdata,
  output logic             en_o,
  output logic             irq_en_o,
  output logic             clr_o,
  output logic [CNT_W-1:0] cmp_o
);
  localparam int EN_POS  = BUS_W - 1;
  localparam int CLR_POS = BUS_W - 2;
  localparam int IE_POS  = BUS_W - 3;

  assign clr_o = we & wdata[CLR_POS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o     <= 1'b0;
      irq_en_o <= 1'b0;
      cmp_o    <= '0;
    end else if (we) begin
      en_o     <= wdata[EN_POS];
      irq_en_o <= wdata[IE_POS];
      cmp_o    <= wdata[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] cnt_o,
  output tmr_pkg::act_e    act_o
);
  import tmr_pkg::*;

  always_comb begin
    if (clr)               act_o = ACT_CLEAR;
    else if (!en)          act_o = ACT_HOLD;
    else if (cnt_o == cmp) act_o = ACT_WRAP;
    else                   act_o = ACT_STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o <= '0;
    end else begin
      case (act_o)
        ACT_STEP:  cnt_o <= cnt_o + 1'b1;
        ACT_WRAP,
        ACT_CLEAR: cnt_o <= '0;
        default:   cnt_o <= cnt_o;
      endcase
    end
  end
endmodule

// File: rtl/tmr_wrap_out.sv
module tmr_wrap_out (
  input  logic          clk,
  input  logic          rst_n,
  input  tmr_pkg::act_e act,
  input  logic          irq_en,
  output logic          q_o,
  output logic          nq_o,
  output logic          irq_o
);
  import tmr_pkg::*;

  logic wrap;
  assign wrap = (act == ACT_WRAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o   <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      if (wrap) q_o <= ~q_o;
      irq_o <= wrap & irq_en;
    end
  end

  assign nq_o = ~q_o;
endmodule

// File: rtl/cmp_wrap_timer.sv
module cmp_wrap_timer #(
  parameter int CNT_W = 13,
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [BUS_W-1:0] ctl_wdata,
  output logic [BUS_W-1:0] count_rd,
  output logic             q_out,
  output logic             nq_out,
  output logic             irq_pulse
);
  localparam int PAD_W = BUS_W - CNT_W;

  logic             ctl_en;
  logic             ctl_ie;
  logic             ctl_clr;
  logic [CNT_W-1:0] cmp_val;
  logic [CNT_W-1:0] cnt;
  tmr_pkg::act_e    act;

  tmr_ctl_reg #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (ctl_we),
    .wdata    (ctl_wdata),
    .en_o     (ctl_en),
    .irq_en_o (ctl_ie),
    .clr_o    (ctl_clr),
    .cmp_o    (cmp_val)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (ctl_en),
    .clr   (ctl_clr),
    .cmp   (cmp_val),
    .cnt_o (cnt),
    .act_o (act)
  );

  tmr_wrap_out u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .act    (act),
    .irq_en (ctl_ie),
    .q_o    (q_out),
    .nq_o   (nq_out),
    .irq_o  (irq_pulse)
  );

  assign count_rd = {{PAD_W{1'b0}}, cnt};
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CNT_W = 13,
  parameter int BUS_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_we,
  input logic [BUS_W-1:0] ctl_wdata,
  input logic [BUS_W-1:0] count_rd,
  input logic             q_out,
  input logic             nq_out,
  input logic             irq_pulse,
  input logic             ctl_en,
  input logic             ctl_ie,
  input logic [CNT_W-1:0] cmp_val
);
  logic             clr_req;
  logic [CNT_W-1:0] cnt;
  assign clr_req = ctl_we & ctl_wdata[BUS_W-2];
  assign cnt     = count_rd[CNT_W-1:0];

  // R3
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_en && !clr_req && cnt != cmp_val) |=> cnt == CNT_W'($past(cnt) + 1'b1));

  // R4
  a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_en && !clr_req && cnt == cmp_val) |=> (cnt == '0 && q_out != $past(q_out)));

  // R5
  a_r5_nq_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    nq_out == !q_out);

  // R6
  a_r6_irq_after_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> (cnt == '0 && $past(ctl_ie) && q_out != $past(q_out)));

  // R7
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> (cnt == '0 && $stable(q_out) && !irq_pulse));

  // R8
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_en && !clr_req) |=> ($stable(count_rd) && $stable(q_out)));

  // R9
  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    count_rd[BUS_W-1:CNT_W] == '0);
endmodule

bind cmp_wrap_timer tmr_checker #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl_we    (ctl_we),
  .ctl_wdata (ctl_wdata),
  .count_rd  (count_rd),
  .q_out     (q_out),
  .nq_out    (nq_out),
  .irq_pulse (irq_pulse),
  .ctl_en    (ctl_en),
  .ctl_ie    (ctl_ie),
  .cmp_val   (cmp_val)
);

// File: tb/cmp_wrap_timer_tb.sv
`timescale 1ns/1ps
module cmp_wrap_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [15:0] ctl_wdata = 16'h0;
  logic [15:0] count_rd;
  logic        q_out, nq_out, irq_pulse;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference state
  logic [12:0] m_cnt = 13'd0;
  logic        m_q = 1'b0, m_irq = 1'b0, m_en = 1'b0, m_ie = 1'b0;
  logic [12:0] m_cmp = 13'd0;
  string       m_tag = "R1";

  always #5 clk = ~clk;

  cmp_wrap_timer u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .count_rd(count_rd), .q_out(q_out), .nq_out(nq_out), .irq_pulse(irq_pulse)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_q = 0; m_irq = 0; m_en = 0; m_ie = 0; m_cmp = 0; m_tag = "R1";
    end else begin
      m_irq = 1'b0;
      if (ctl_we && ctl_wdata[14]) begin
        m_cnt = 0; m_tag = "R7";
      end else if (!m_en) begin
        m_tag = "R8";
      end else if (m_cnt == m_cmp) begin
        m_cnt = 0; m_q = ~m_q; m_irq = m_ie;
        m_tag = (m_cmp == 0) ? "R10" : "R4";
      end else begin
        m_tag = (m_cnt == 13'h1fff) ? "R10" : "R3";
        m_cnt = m_cnt + 1'b1;
      end
      if (ctl_we) begin
        m_en = ctl_wdata[15]; m_ie = ctl_wdata[13]; m_cmp = ctl_wdata[12:0];
      end
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmp_model();
    chk(m_tag, count_rd, {3'b000, m_cnt});
    chk("R9", {13'd0, count_rd[15:13]}, 16'd0);
    chk("R5", {15'd0, q_out}, {15'd0, m_q});
    chk("R5", {15'd0, nq_out}, {15'd0, ~m_q});
    chk("R6", {15'd0, irq_pulse}, {15'd0, m_irq});
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cmp_model();
  endtask

  task automatic wr(logic [15:0] d);
    ctl_we = 1'b1; ctl_wdata = d;
    tick();
    ctl_we = 1'b0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_up();
  end

  initial begin
    logic q_keep;
    void'($urandom(32'd20240611));
    #23;
    chk("R1", count_rd, 16'd0);
    chk("R1", {15'd0, q_out}, 16'd0);
    chk("R1", {15'd0, nq_out}, 16'd1);
    chk("R1", {15'd0, irq_pulse}, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) tick();
    chk("R1", count_rd, 16'd0);

    // enable, irq on, compare 3
    wr(16'hA003);
    chk("R2", count_rd, 16'd0);
    tick(); chk("R2", count_rd, 16'd1);
    tick(); chk("R3", count_rd, 16'd2);
    tick(); chk("R3", count_rd, 16'd3);
    tick();
    chk("R4", count_rd, 16'd0);
    chk("R5", {15'd0, q_out}, 16'd1);
    chk("R6", {15'd0, irq_pulse}, 16'd1);
    tick();
    chk("R6", {15'd0, irq_pulse}, 16'd0);
    chk("R3", count_rd, 16'd1);

    // disable: last step at the write edge, then hold
    wr(16'h0003);
    chk("R2", count_rd, 16'd2);
    tick(); tick();
    chk("R8", count_rd, 16'd2);

    // clear while disabled
    wr(16'h4003);
    chk("R7", count_rd, 16'd0);
    tick();
    chk("R7", count_rd, 16'd0);

    // compare 0, irq off: wrap every cycle
    wr(16'h8000);
    q_keep = q_out;
    tick();
    chk("R10", {15'd0, q_out}, {15'd0, ~q_keep});
    tick();
    chk("R10", {15'd0, q_out}, {15'd0, q_keep});
    chk("R6", {15'd0, irq_pulse}, 16'd0);

    // clear overrides a pending wrap
    q_keep = q_out;
    wr(16'hC000);
    chk("R7", {15'd0, q_out}, {15'd0, q_keep});
    chk("R7", {15'd0, irq_pulse}, 16'd0);

    // compare below count: full rollover without toggle
    wr(16'hA064);
    for (int i = 0; i < 10; i++) tick();
    wr(16'h8002);
    q_keep = q_out;
    for (int i = 0; i < 9000 && count_rd != 16'd0; i++) tick();
    chk("R10", count_rd, 16'd0);
    chk("R10", {15'd0, q_out}, {15'd0, q_keep});
    tick(); tick(); tick();
    chk("R10", {15'd0, q_out}, {15'd0, ~q_keep});

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 15) == 0) begin
        logic [15:0] d;
        d = 16'($urandom);
        d[12:0] = 13'($urandom_range(0, 24));
        d[15] = ($urandom_range(0, 4) != 0);
        d[14] = ($urandom_range(0, 5) == 0);
        wr(d);
      end else begin
        tick();
      end
    end
    finish_up();
  end
endmodule